// File: doc/BRIEF.md
# Addressed Synthesizer Control Latch Bank

This block is the device-side register file of a frequency synthesizer. A three-wire serial port (serial clock, serial data, load strobe) shifts a 24-bit control word in, most significant bit first. When the load strobe rises, the word's two lowest bits pick where its upper 22 bits go. Those bits go to one of three latches: the reference-divider latch, the feedback-divider latch or the function latch. The fourth code is reserved and changes nothing.

The function latch drives two controls. One puts the charge-pump output into high impedance. The other holds both divider counters at zero. A chip-enable pin powers the block down at once, with no clock edge needed. Power-down clears both counters while the latch contents are kept. When chip-enable returns high, both counters restart from zero in the same cycle, so their counts stay aligned.

Two plain divider counters stand in for the reference and feedback paths, so that hold, restart and alignment can be seen at the ports. The serial inputs are synchronised into the system clock domain. The chip-enable path is not synchronised.

Top module: `synth_latch_bank`

## Requirements
- R1: A word is shifted in MSB first on rising serial-clock edges. When the load strobe rises with address bits [1:0] = 00, word bits [23:2] are stored in the reference latch (`ref_latch`), and no other latch changes.
- R2: Address 01 stores word bits [23:2] in the feedback latch (`fb_latch`), and no other latch changes.
- R3: Address 10 stores word bits [23:2] in the function latch (`fn_latch`), and no other latch changes.
- R4: Address 11 is reserved. A load with this address leaves all three latches unchanged.
- R5: Power-on reset clears all three latches to zero, so `cp_hiz` = 0, `cnt_hold` = 0, and both counters read 0.
- R6: Function word bit 8 (`fn_latch[6]`) set to 1 drives `cp_hiz` high. Set to 0, with chip-enable high, it drives `cp_hiz` low.
- R7: Function word bit 2 (`fn_latch[0]`) set to 1 raises `cnt_hold` and holds both counters at 0. Clearing it releases both counters in the same cycle.
- R8: When `chip_en` goes low, `pwr_down` rises, `cp_hiz` rises and both counters clear at once, without waiting for a clock edge.
- R9: After `chip_en` returns high, both counters count up from 0 together. N clock edges after the rise, each counter reads N, as long as N is below both moduli.
- R10: Latch contents survive chip-enable low, and loads made while powered down take effect.
- R11: The reference counter counts modulo word bits [15:2] of its latch. The feedback counter counts modulo word bits [20:8] of its latch. A divide value of 0 acts as 1. Each counter's tick output is high while its count equals its modulus minus 1 and the counters are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the serial port, latches and counters |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low powers the block down asynchronously |
| cp_hiz | output | 1 | Charge-pump output high-impedance control |
| cnt_hold | output | 1 | Counter reset hold from the function latch |
| pwr_down | output | 1 | Power-down state |
| ref_latch | output | 22 | Reference latch contents (word bits 23:2) |
| fb_latch | output | 22 | Feedback latch contents (word bits 23:2) |
| fn_latch | output | 22 | Function latch contents (word bits 23:2) |
| ref_cnt | output | 14 | Reference divider count |
| fb_cnt | output | 13 | Feedback divider count |
| ref_tick | output | 1 | Reference terminal-count pulse |
| fb_tick | output | 1 | Feedback terminal-count pulse |

## Verification
The hardest case to reach is two counters that are both running, released at the same moment, and then checked for equal counts before either one wraps. To get there, the stimulus first loads moduli of 20 and 30 through the serial port. It then either lowers and raises chip-enable, or sets and clears the counter-hold bit with a second function load, and checks the counts within the first few cycles. The reserved address is mixed into a seeded random stream of loads, so each ignored load is followed at once by a readback of all three latches.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int NUM_LATCH = 3;

  // Field positions inside the 22-bit payload (word bit minus ADDR_W)
  localparam int REF_LO  = 0;
  localparam int REF_W   = 14;
  localparam int FB_LO   = 6;
  localparam int FB_W    = 13;
  localparam int FN_CRST = 0;
  localparam int FN_HIZ  = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADR_REF  = 2'b00,
    ADR_FB   = 2'b01,
    ADR_FN   = 2'b10,
    ADR_RSVD = 2'b11
  } slb_addr_e;

  function automatic slb_addr_e word_addr(input logic [WORD_W-1:0] w);
    return slb_addr_e'(w[ADDR_W-1:0]);
  endfunction

  function automatic logic [PAY_W-1:0] word_payload(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W];
  endfunction
endpackage

// File: rtl/slb_serial_rx.sv
module slb_serial_rx
  import slb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic              load_pulse,
  output logic [WORD_W-1:0] load_word
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] clk_sync, le_sync, dat_sync;
  logic          sclk_rise, le_rise;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      le_sync  <= '0;
      dat_sync <= '0;
    end else begin
      clk_sync <= {clk_sync[SW-2:0], ser_clk};
      le_sync  <= {le_sync[SW-2:0], ser_le};
      dat_sync <= {dat_sync[SW-2:0], ser_data};
    end
  end

  assign sclk_rise = clk_sync[SW-2] & ~clk_sync[SW-1];
  assign le_rise   = le_sync[SW-2] & ~le_sync[SW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      load_word  <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= le_rise;
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], dat_sync[SW-2]};
      if (le_rise)   load_word <= shreg;
    end
  end
endmodule

// File: rtl/slb_latch_bank.sv
module slb_latch_bank
  import slb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_pulse,
  input  logic [WORD_W-1:0] load_word,
  output logic [NUM_LATCH-1:0] wr_sel,
  output logic [PAY_W-1:0]  ref_q,
  output logic [PAY_W-1:0]  fb_q,
  output logic [PAY_W-1:0]  fn_q
);
  logic [PAY_W-1:0] store [NUM_LATCH];
  slb_addr_e        addr;

  assign addr = word_addr(load_word);

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    assign wr_sel[i] = load_pulse && (addr == slb_addr_e'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         store[i] <= '0;
      else if (wr_sel[i]) store[i] <= word_payload(load_word);
    end
  end

  assign ref_q = store[ADR_REF];
  assign fb_q  = store[ADR_FB];
  assign fn_q  = store[ADR_FN];
endmodule

// File: rtl/slb_div_counter.sv
module slb_div_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         hold,
  input  logic [W-1:0] div,
  output logic [W-1:0] cnt,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] last_count(input logic [W-1:0] d);
    return (d == '0) ? '0 : d - ONE;
  endfunction

  logic at_end;
  assign at_end = (cnt >= last_count(div));
  assign tick   = !hold && at_end;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + ONE;
  end
endmodule

// File: rtl/synth_latch_bank.sv
module synth_latch_bank
  import slb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  input  logic               chip_en,
  output logic               cp_hiz,
  output logic               cnt_hold,
  output logic               pwr_down,
  output logic [PAY_W-1:0]   ref_latch,
  output logic [PAY_W-1:0]   fb_latch,
  output logic [PAY_W-1:0]   fn_latch,
  output logic [REF_W-1:0]   ref_cnt,
  output logic [FB_W-1:0]    fb_cnt,
  output logic               ref_tick,
  output logic               fb_tick
);
  logic              load_pulse;
  logic [WORD_W-1:0] load_word;
  logic [NUM_LATCH-1:0] wr_sel;
  logic              ref_wr, fb_wr, fn_wr;
  logic              cnt_clr_n;

  slb_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .load_pulse(load_pulse), .load_word(load_word)
  );

  slb_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .load_word(load_word),
    .wr_sel(wr_sel), .ref_q(ref_latch), .fb_q(fb_latch), .fn_q(fn_latch)
  );

  assign ref_wr = wr_sel[ADR_REF];
  assign fb_wr  = wr_sel[ADR_FB];
  assign fn_wr  = wr_sel[ADR_FN];

  assign pwr_down  = !chip_en;
  assign cnt_hold  = fn_latch[FN_CRST];
  assign cp_hiz    = fn_latch[FN_HIZ] | pwr_down;
  assign cnt_clr_n = rst_n & chip_en;

  slb_div_counter #(.W(REF_W)) u_ref_cnt (
    .clk(clk), .clr_n(cnt_clr_n), .hold(cnt_hold),
    .div(ref_latch[REF_LO +: REF_W]), .cnt(ref_cnt), .tick(ref_tick)
  );

  slb_div_counter #(.W(FB_W)) u_fb_cnt (
    .clk(clk), .clr_n(cnt_clr_n), .hold(cnt_hold),
    .div(fb_latch[FB_LO +: FB_W]), .cnt(fb_cnt), .tick(fb_tick)
  );
endmodule

// File: rtl/slb_checker.sv
module slb_checker
  import slb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              load_pulse,
  input logic [WORD_W-1:0] load_word,
  input logic              ref_wr,
  input logic              fb_wr,
  input logic              fn_wr,
  input logic              cnt_hold,
  input logic [PAY_W-1:0]  ref_latch,
  input logic [PAY_W-1:0]  fb_latch,
  input logic [PAY_W-1:0]  fn_latch,
  input logic [REF_W-1:0]  ref_cnt,
  input logic [FB_W-1:0]   fb_cnt
);
  AST_ONE_LATCH_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_wr, fb_wr, fn_wr})); // R1

  AST_REF_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && load_word[1:0] == 2'b00) |=> ref_latch == $past(load_word[WORD_W-1:ADDR_W])); // R1

  AST_FN_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && load_word[1:0] == 2'b10) |=> fn_latch == $past(load_word[WORD_W-1:ADDR_W])); // R3

  AST_RSVD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && load_word[1:0] == 2'b11) |=>
      ($stable(ref_latch) && $stable(fb_latch) && $stable(fn_latch))); // R4

  AST_HOLD_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold && $past(cnt_hold)) |-> (ref_cnt == '0 && fb_cnt == '0)); // R7

  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (ref_cnt == '0 && fb_cnt == '0)); // R8

  AST_RESTART_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_en) |-> (ref_cnt == '0 && fb_cnt == '0)); // R9
endmodule

bind synth_latch_bank slb_checker u_slb_checker (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .load_pulse(load_pulse),
  .load_word(load_word), .ref_wr(ref_wr), .fb_wr(fb_wr), .fn_wr(fn_wr),
  .cnt_hold(cnt_hold), .ref_latch(ref_latch), .fb_latch(fb_latch),
  .fn_latch(fn_latch), .ref_cnt(ref_cnt), .fb_cnt(fb_cnt)
);

// File: tb/synth_latch_bank_bench.sv
module synth_latch_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic        cp_hiz, cnt_hold, pwr_down, ref_tick, fb_tick;
  logic [21:0] ref_latch, fb_latch, fn_latch;
  logic [13:0] ref_cnt;
  logic [12:0] fb_cnt;

  int n_checks = 0;
  int n_fail = 0;
  logic [21:0] exp_ref = '0, exp_fb = '0, exp_fn = '0;

  always #4 clk = ~clk;

  synth_latch_bank u_synth_latch_bank (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .chip_en(chip_en), .cp_hiz(cp_hiz), .cnt_hold(cnt_hold),
    .pwr_down(pwr_down), .ref_latch(ref_latch), .fb_latch(fb_latch),
    .fn_latch(fn_latch), .ref_cnt(ref_cnt), .fb_cnt(fb_cnt),
    .ref_tick(ref_tick), .fb_tick(fb_tick)
  );

  function automatic logic [23:0] mk_word(input logic [21:0] pay, input logic [1:0] adr);
    return {pay, adr};
  endfunction

  function automatic logic [21:0] ref_pay(input int div);
    return 22'(div);
  endfunction

  function automatic logic [21:0] fb_pay(input int div);
    return 22'(div) << 6;
  endfunction

  function automatic logic [21:0] fn_pay(input bit crst, input bit hiz);
    return (22'(hiz) << 6) | 22'(crst);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(2);
    ser_le = 1'b1;
    wait_cyc(4);
    ser_le = 1'b0;
    wait_cyc(4);
    case (w[1:0])
      2'b00: exp_ref = w[23:2];
      2'b01: exp_fb  = w[23:2];
      2'b10: exp_fn  = w[23:2];
      default: ;
    endcase
  endtask

  task automatic check_latches(input string req);
    check(req, 32'(ref_latch), 32'(exp_ref));
    check(req, 32'(fb_latch), 32'(exp_fb));
    check(req, 32'(fn_latch), 32'(exp_fn));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] r_snap;
    logic [12:0] f_snap;
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R5 reset state
    check("R5 latches", 32'(ref_latch | fb_latch | fn_latch), 0);
    check("R5 cp_hiz", 32'(cp_hiz), 0);
    check("R5 cnt_hold", 32'(cnt_hold), 0);
    check("R5 counts", 32'(ref_cnt) + 32'(fb_cnt), 0);

    // Directed loads to each address
    send(mk_word(22'h2A5A5A, 2'b00)); check_latches("R1");
    send(mk_word(22'h15A5A5, 2'b01)); check_latches("R2");
    send(mk_word(22'h3C0FF0, 2'b10)); check_latches("R3");
    send(mk_word(22'h3FFFFF, 2'b11)); check_latches("R4");

    // Random mix, reserved address included
    for (int k = 0; k < 30; k++) begin
      logic [23:0] w;
      w = 24'($urandom);
      send(w);
      if (w[1:0] == 2'b11) check_latches("R4 random");
      else check_latches("R1 R2 R3 random");
    end

    // Counter setup: R=20, N=30, hold set, output tri-stated
    send(mk_word(ref_pay(20), 2'b00));
    send(mk_word(fb_pay(30), 2'b01));
    send(mk_word(fn_pay(1'b1, 1'b1), 2'b10));
    wait_cyc(3);
    check("R6 hiz on", 32'(cp_hiz), 1);
    check("R7 hold flag", 32'(cnt_hold), 1);
    check("R7 held zero", 32'(ref_cnt) + 32'(fb_cnt), 0);

    // Release hold, output enabled
    send(mk_word(fn_pay(1'b0, 1'b0), 2'b10));
    check("R6 hiz off", 32'(cp_hiz), 0);
    check("R7 hold off", 32'(cnt_hold), 0);
    check("R7 aligned release", 32'(ref_cnt), 32'(fb_cnt));
    check("R7 running", 32'(ref_cnt != 0), 1);

    // R11 moduli and tick
    r_snap = ref_cnt; f_snap = fb_cnt;
    wait_cyc(20);
    check("R11 ref modulus", 32'(ref_cnt), 32'(r_snap));
    wait_cyc(10);
    check("R11 fb modulus", 32'(fb_cnt), 32'(f_snap));
    while (ref_cnt != 14'd19) @(negedge clk);
    check("R11 ref tick", 32'(ref_tick), 1);
    wait_cyc(1);
    check("R11 ref wrap", 32'(ref_cnt), 0);

    // R8 asynchronous power-down
    wait_cyc(3);
    chip_en = 1'b0;
    #1;
    check("R8 pwr_down", 32'(pwr_down), 1);
    check("R8 hiz", 32'(cp_hiz), 1);
    check("R8 ref clear", 32'(ref_cnt), 0);
    check("R8 fb clear", 32'(fb_cnt), 0);

    // R10 retention and load while powered down
    wait_cyc(5);
    check_latches("R10 retained");
    send(mk_word(ref_pay(25), 2'b00));
    check_latches("R10 load in pd");
    check("R10 counts still zero", 32'(ref_cnt) + 32'(fb_cnt), 0);

    // R9 aligned restart
    @(negedge clk);
    chip_en = 1'b1;
    wait_cyc(3);
    check("R9 ref count", 32'(ref_cnt), 3);
    check("R9 fb count", 32'(fb_cnt), 3);
    check("R9 pwr_down off", 32'(pwr_down), 0);
    check_latches("R10 after restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule